// File: doc/BRIEF.md
# NAND Timing Parameter Calculator

This block turns a NAND device's interface timing limits, given in picoseconds, into the clock-cycle counts that a static memory controller needs in its control and timing registers. The host presents the controller clock period in nanoseconds and the fourteen timing limits, then pulses `start_i`. The block checks that the device is not too fast for the controller and derives six cycle fields. Each field has its own rule: which limits feed it, whether one cycle is taken off, whether zero is raised to one, and where it saturates. It then reports the fields both one by one and packed into two register words.

Every field needs a ceiling division by the clock period. One iterative restoring divider is shared across the six fields, so a full calculation takes about two hundred cycles. The results are held until the next accepted start. A start that arrives while a calculation is running is dropped.

Top module: `nand_timing_calc`

## Requirements
- R1: If the read-cycle minimum is below 30000 ps, the block raises `unsupported_o`, sets all six fields and both packed words to 0, and pulses `done_o` without dividing. A read-cycle minimum of exactly 30000 ps is accepted.
- R2: CLE gap and ALE gap are each ceil(trunc(ps/1000)/period) minus one. A ceiling of 0 stays 0. Each is a 4-bit field that saturates at 15.
- R3: HIZ is ceil(trunc(D/1000)/period) with no offset and saturates at 255, where D is the CE setup minus the WE pulse, clamped at 0.
- R4: HOLD is the largest of data hold, CE hold, CLE hold, WE high, ALE hold and RE high, converted with a ceiling and no offset. A result of 0 becomes 1, and it saturates at 255.
- R5: WAIT is the larger of RE pulse and WE pulse, converted with a ceiling minus one. A result of 0 becomes 1, and it saturates at 255.
- R6: SETUP is the larger of (CE setup − WE pulse) and (CE access − RE access), each difference clamped at 0, converted with a ceiling minus one. A result of 0 becomes 1, and it saturates at 255.
- R7: `ctrl_word_o` carries CLE gap in bits 12:9 and ALE gap in bits 16:13, and every other bit is 0. `timing_word_o` carries SETUP in 7:0, WAIT in 15:8, HOLD in 23:16 and HIZ in 31:24.
- R8: `done_o` is high for exactly one cycle per accepted start. A start that arrives while a calculation is running is ignored and is not queued.
- R9: All outputs other than `done_o` change only in the cycle in which `done_o` is high, and stay unchanged otherwise.
- R10: Picosecond inputs are truncated to whole nanoseconds before the ceiling division. For example, 1999 ps counts as 1 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; inputs are sampled on this cycle |
| period_ns_i | input | 8 | Controller clock period in ns; must be nonzero |
| rd_cycle_ps_i | input | 32 | Read-cycle minimum |
| cle_rd_ps_i | input | 32 | CLE to RE delay minimum |
| ale_rd_ps_i | input | 32 | ALE to RE delay minimum |
| ce_setup_ps_i | input | 32 | CE setup minimum |
| we_pulse_ps_i | input | 32 | WE pulse width minimum |
| data_hold_ps_i | input | 32 | Data hold minimum |
| ce_hold_ps_i | input | 32 | CE hold minimum |
| cle_hold_ps_i | input | 32 | CLE hold minimum |
| we_high_ps_i | input | 32 | WE high time minimum |
| ale_hold_ps_i | input | 32 | ALE hold minimum |
| re_high_ps_i | input | 32 | RE high time minimum |
| re_pulse_ps_i | input | 32 | RE pulse width minimum |
| ce_access_ps_i | input | 32 | CE access time maximum |
| re_access_ps_i | input | 32 | RE access time maximum |
| cle_gap_o | output | 4 | CLE gap cycles |
| ale_gap_o | output | 4 | ALE gap cycles |
| hiz_cyc_o | output | 8 | Bus turnaround cycles |
| hold_cyc_o | output | 8 | Hold cycles |
| wait_cyc_o | output | 8 | Strobe wait cycles |
| setup_cyc_o | output | 8 | Setup cycles |
| ctrl_word_o | output | 32 | Packed control word |
| timing_word_o | output | 32 | Packed timing word |
| unsupported_o | output | 1 | Device too fast for the controller |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions check on every cycle that each divider result is exact (quotient times divisor plus remainder equals the dividend, and the remainder is smaller than the divisor). They also check that the done pulse lasts a single cycle, that the outputs hold between pulses, that the floored fields are never zero at completion, that a rejected configuration leaves both words at zero, and that the 4-bit gaps never carry bits above their width. The per-field rules can only be shown by the bench's scenarios: which limit wins a maximum, the minus-one and its underflow guard, saturation, clamping of negative differences, truncation to whole nanoseconds, the 30000 ps boundary, and a start that is dropped while a calculation is busy.

// File: rtl/nand_tc_pkg.sv
package nand_tc_pkg;
  localparam int NUM_FIELDS = 6;
  localparam int OUT_MAX_W  = 8;

  // field index order: cle gap, ale gap, hiz, hold, wait, setup
  localparam int FLD_CLE   = 0;
  localparam int FLD_ALE   = 1;
  localparam int FLD_HIZ   = 2;
  localparam int FLD_HOLD  = 3;
  localparam int FLD_WAIT  = 4;
  localparam int FLD_SETUP = 5;

  // bit i set: field i takes the minus-one offset / the floor of one
  localparam logic [NUM_FIELDS-1:0] DEC_MASK   = 6'b110011;
  localparam logic [NUM_FIELDS-1:0] FLOOR_MASK = 6'b111000;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_WAIT, ST_FINISH} seq_state_e;

  function automatic int field_width(int idx);
    return (idx < 2) ? 4 : 8;
  endfunction
endpackage

// File: rtl/nand_tc_divider.sv
module nand_tc_divider #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quotient_o
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     rem_q, quo_q, dvs_q, dvd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;
  logic [W:0]       shifted;
  logic             take;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    take    = shifted >= {1'b0, dvs_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      dvd_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        rem_q  <= '0;
        quo_q  <= dividend_i;
        dvd_q  <= dividend_i;
        dvs_q  <= divisor_i;
        cnt_q  <= CNT_W'(W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= take ? W'(shifted - {1'b0, dvs_q}) : shifted[W-1:0];
        quo_q <= {quo_q[W-2:0], take};
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o     = done_q;
  assign quotient_o = quo_q;

  logic [2*W-1:0] recon;
  assign recon = (2*W)'(quo_q) * (2*W)'(dvs_q) + (2*W)'(rem_q);

  assert_div_exact_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (recon == (2*W)'(dvd_q)) && (rem_q < dvs_q));
endmodule

// File: rtl/nand_tc_field.sv
module nand_tc_field #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 8,
  parameter bit DEC   = 1'b0,
  parameter bit FLOOR = 1'b0
) (
  input  logic [IN_W-1:0]  cycles_i,
  output logic [OUT_W-1:0] value_o
);
  localparam logic [IN_W-1:0] LIMIT = IN_W'((64'd1 << OUT_W) - 64'd1);

  logic [IN_W-1:0] dec, flr;

  always_comb begin
    dec = cycles_i;
    // zero stays zero: no wrap on the offset
    if (DEC && (cycles_i != '0)) dec = cycles_i - IN_W'(1);
    flr = dec;
    if (FLOOR && (dec == '0)) flr = IN_W'(1);
    value_o = (flr > LIMIT) ? LIMIT[OUT_W-1:0] : flr[OUT_W-1:0];
  end
endmodule

// File: rtl/nand_timing_calc.sv
module nand_timing_calc
  import nand_tc_pkg::*;
#(
  parameter int          PS_W        = 32,
  parameter int          PERIOD_W    = 8,
  parameter int unsigned RC_LIMIT_PS = 30000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [PERIOD_W-1:0] period_ns_i,
  input  logic [PS_W-1:0]     rd_cycle_ps_i,
  input  logic [PS_W-1:0]     cle_rd_ps_i,
  input  logic [PS_W-1:0]     ale_rd_ps_i,
  input  logic [PS_W-1:0]     ce_setup_ps_i,
  input  logic [PS_W-1:0]     we_pulse_ps_i,
  input  logic [PS_W-1:0]     data_hold_ps_i,
  input  logic [PS_W-1:0]     ce_hold_ps_i,
  input  logic [PS_W-1:0]     cle_hold_ps_i,
  input  logic [PS_W-1:0]     we_high_ps_i,
  input  logic [PS_W-1:0]     ale_hold_ps_i,
  input  logic [PS_W-1:0]     re_high_ps_i,
  input  logic [PS_W-1:0]     re_pulse_ps_i,
  input  logic [PS_W-1:0]     ce_access_ps_i,
  input  logic [PS_W-1:0]     re_access_ps_i,
  output logic [3:0]          cle_gap_o,
  output logic [3:0]          ale_gap_o,
  output logic [7:0]          hiz_cyc_o,
  output logic [7:0]          hold_cyc_o,
  output logic [7:0]          wait_cyc_o,
  output logic [7:0]          setup_cyc_o,
  output logic [31:0]         ctrl_word_o,
  output logic [31:0]         timing_word_o,
  output logic                unsupported_o,
  output logic                done_o
);
  localparam int              IDX_W     = $clog2(NUM_FIELDS);
  localparam logic [PS_W-1:0] PS_PER_NS = PS_W'(1000);
  localparam logic [PS_W-1:0] RC_LIMIT  = PS_W'(RC_LIMIT_PS);

  function automatic logic [PS_W-1:0] max_ps(logic [PS_W-1:0] a, logic [PS_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [PS_W-1:0] sub_ps(logic [PS_W-1:0] a, logic [PS_W-1:0] b);
    return (a > b) ? (a - b) : '0;
  endfunction

  logic [PS_W-1:0]      src      [NUM_FIELDS];
  logic [PS_W-1:0]      num_q    [NUM_FIELDS];
  logic [PS_W-1:0]      quo_q    [NUM_FIELDS];
  logic [OUT_MAX_W-1:0] fld_next [NUM_FIELDS];
  logic [OUT_MAX_W-1:0] fld_q    [NUM_FIELDS];
  logic [PS_W-1:0]      period_ext, period_q;
  logic [IDX_W-1:0]     idx_q;
  seq_state_e           state_q;
  logic                 unsup_q, done_q;
  logic                 div_start, div_done;
  logic [PS_W-1:0]      div_quo;

  assign period_ext = PS_W'(period_ns_i);

  always_comb begin
    src[FLD_CLE]   = cle_rd_ps_i;
    src[FLD_ALE]   = ale_rd_ps_i;
    src[FLD_HIZ]   = sub_ps(ce_setup_ps_i, we_pulse_ps_i);
    src[FLD_HOLD]  = max_ps(max_ps(max_ps(data_hold_ps_i, ce_hold_ps_i),
                                   max_ps(cle_hold_ps_i, we_high_ps_i)),
                            max_ps(ale_hold_ps_i, re_high_ps_i));
    src[FLD_WAIT]  = max_ps(re_pulse_ps_i, we_pulse_ps_i);
    src[FLD_SETUP] = max_ps(sub_ps(ce_setup_ps_i, we_pulse_ps_i),
                            sub_ps(ce_access_ps_i, re_access_ps_i));
  end

  assign div_start = (state_q == ST_LOAD);

  nand_tc_divider #(.W(PS_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (div_start),
    .dividend_i (num_q[idx_q]),
    .divisor_i  (period_q),
    .done_o     (div_done),
    .quotient_o (div_quo)
  );

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    logic [field_width(g)-1:0] fld_val;
    nand_tc_field #(
      .IN_W  (PS_W),
      .OUT_W (field_width(g)),
      .DEC   (DEC_MASK[g]),
      .FLOOR (FLOOR_MASK[g])
    ) u_fld (
      .cycles_i (quo_q[g]),
      .value_o  (fld_val)
    );
    assign fld_next[g] = OUT_MAX_W'(fld_val);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      period_q <= '0;
      unsup_q  <= 1'b0;
      done_q   <= 1'b0;
      for (int i = 0; i < NUM_FIELDS; i++) begin
        num_q[i] <= '0;
        quo_q[i] <= '0;
        fld_q[i] <= '0;
      end
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (rd_cycle_ps_i < RC_LIMIT) begin
            unsup_q <= 1'b1;
            done_q  <= 1'b1;
            for (int i = 0; i < NUM_FIELDS; i++) fld_q[i] <= '0;
          end else begin
            // truncate to ns, then bias for ceiling division
            for (int i = 0; i < NUM_FIELDS; i++)
              num_q[i] <= src[i] / PS_PER_NS + period_ext - PS_W'(1);
            period_q <= period_ext;
            idx_q    <= '0;
            state_q  <= ST_LOAD;
          end
        end
        ST_LOAD: state_q <= ST_WAIT;
        ST_WAIT: if (div_done) begin
          quo_q[idx_q] <= div_quo;
          if (idx_q == IDX_W'(NUM_FIELDS - 1)) begin
            state_q <= ST_FINISH;
          end else begin
            idx_q   <= idx_q + IDX_W'(1);
            state_q <= ST_LOAD;
          end
        end
        ST_FINISH: begin
          for (int i = 0; i < NUM_FIELDS; i++) fld_q[i] <= fld_next[i];
          unsup_q <= 1'b0;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cle_gap_o     = fld_q[FLD_CLE][3:0];
  assign ale_gap_o     = fld_q[FLD_ALE][3:0];
  assign hiz_cyc_o     = fld_q[FLD_HIZ];
  assign hold_cyc_o    = fld_q[FLD_HOLD];
  assign wait_cyc_o    = fld_q[FLD_WAIT];
  assign setup_cyc_o   = fld_q[FLD_SETUP];
  assign ctrl_word_o   = {15'd0, ale_gap_o, cle_gap_o, 9'd0};
  assign timing_word_o = {hiz_cyc_o, hold_cyc_o, wait_cyc_o, setup_cyc_o};
  assign unsupported_o = unsup_q;
  assign done_o        = done_q;

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_unsup_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unsupported_o |-> (ctrl_word_o == 32'd0) && (timing_word_o == 32'd0));

  assert_hold_floor_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !unsupported_o) |-> (hold_cyc_o != 8'd0));

  assert_wait_floor_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !unsupported_o) |-> (wait_cyc_o != 8'd0));

  assert_setup_floor_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !unsupported_o) |-> (setup_cyc_o != 8'd0));

  assert_gap_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fld_q[FLD_CLE][7:4] == 4'd0) && (fld_q[FLD_ALE][7:4] == 4'd0));

  assert_outputs_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(ctrl_word_o) && $stable(timing_word_o) && $stable(unsupported_o)));
endmodule

// File: tb/nand_timing_calc_tb.sv
module nand_timing_calc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  period = 8'd10;
  logic [31:0] rc, clr, ar, cs, wp, dh, ch, clh, wh, alh, reh, rp, cea, rea;
  logic [3:0]  cle_gap, ale_gap;
  logic [7:0]  hiz, hold, wt, setup;
  logic [31:0] ctrl_word, timing_word;
  logic        unsup, done;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_timing_calc u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .period_ns_i(period),
    .rd_cycle_ps_i(rc), .cle_rd_ps_i(clr), .ale_rd_ps_i(ar),
    .ce_setup_ps_i(cs), .we_pulse_ps_i(wp), .data_hold_ps_i(dh),
    .ce_hold_ps_i(ch), .cle_hold_ps_i(clh), .we_high_ps_i(wh),
    .ale_hold_ps_i(alh), .re_high_ps_i(reh), .re_pulse_ps_i(rp),
    .ce_access_ps_i(cea), .re_access_ps_i(rea),
    .cle_gap_o(cle_gap), .ale_gap_o(ale_gap), .hiz_cyc_o(hiz),
    .hold_cyc_o(hold), .wait_cyc_o(wt), .setup_cyc_o(setup),
    .ctrl_word_o(ctrl_word), .timing_word_o(timing_word),
    .unsupported_o(unsup), .done_o(done)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint conv(longint ps, longint per, bit dec, bit flr, longint maxv);
    longint ns = ps / 1000;
    longint c  = (ns + per - 1) / per;
    if (dec) c = (c == 0) ? 0 : c - 1;
    if (flr && c == 0) c = 1;
    if (c > maxv) c = maxv;
    return c;
  endfunction

  function automatic longint mx(longint a, longint b);
    return (a > b) ? a : b;
  endfunction

  function automatic longint sb(longint a, longint b);
    return (a > b) ? a - b : 0;
  endfunction

  task automatic set_cfg(int per, int v_rc, int v_clr, int v_ar, int v_cs, int v_wp,
                         int v_dh, int v_ch, int v_clh, int v_wh, int v_alh,
                         int v_reh, int v_rp, int v_cea, int v_rea);
    period = 8'(per); rc = v_rc; clr = v_clr; ar = v_ar; cs = v_cs; wp = v_wp;
    dh = v_dh; ch = v_ch; clh = v_clh; wh = v_wh; alh = v_alh; reh = v_reh;
    rp = v_rp; cea = v_cea; rea = v_rea;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(string req);
    int cnt = 0;
    while (!done && cnt < 2000) begin
      @(negedge clk); cnt++;
    end
    chk(req, "done seen", longint'(done), 1);
    @(negedge clk);
    chk("R8", "done single cycle", longint'(done), 0);
  endtask

  task automatic run_calc(string req);
    pulse_start();
    wait_done(req);
  endtask

  task automatic check_all(string tag);
    longint e_cle, e_ale, e_hiz, e_hold, e_wait, e_setup;
    e_cle   = conv(clr, period, 1, 0, 15);
    e_ale   = conv(ar, period, 1, 0, 15);
    e_hiz   = conv(sb(cs, wp), period, 0, 0, 255);
    e_hold  = conv(mx(mx(mx(dh, ch), mx(clh, wh)), mx(alh, reh)), period, 0, 1, 255);
    e_wait  = conv(mx(rp, wp), period, 1, 1, 255);
    e_setup = conv(mx(sb(cs, wp), sb(cea, rea)), period, 1, 1, 255);
    chk("R1", {tag, " unsupported low"}, longint'(unsup), 0);
    chk("R2", {tag, " cle gap"}, longint'(cle_gap), e_cle);
    chk("R2", {tag, " ale gap"}, longint'(ale_gap), e_ale);
    chk("R3", {tag, " hiz"}, longint'(hiz), e_hiz);
    chk("R4", {tag, " hold"}, longint'(hold), e_hold);
    chk("R5", {tag, " wait"}, longint'(wt), e_wait);
    chk("R6", {tag, " setup"}, longint'(setup), e_setup);
    chk("R7", {tag, " ctrl word"}, longint'(ctrl_word), (e_ale << 13) | (e_cle << 9));
    chk("R7", {tag, " timing word"}, longint'(timing_word),
        (e_hiz << 24) | (e_hold << 16) | (e_wait << 8) | e_setup);
  endtask

  task automatic t_reset();
    chk("R9", "reset ctrl word", longint'(ctrl_word), 0);
    chk("R9", "reset timing word", longint'(timing_word), 0);
    chk("R8", "reset done low", longint'(done), 0);
    chk("R1", "reset unsupported low", longint'(unsup), 0);
  endtask

  task automatic t_basic();
    set_cfg(10, 40000, 10000, 10000, 20000, 12000, 5000, 5000, 5000, 10000,
            5000, 10000, 12000, 25000, 20000);
    run_calc("R2");
    check_all("basic p10");
    set_cfg(3, 50000, 20000, 31000, 45000, 15000, 7000, 22000, 9000, 14000,
            3000, 11000, 26000, 60000, 18000);
    run_calc("R4");
    check_all("basic p3");
    chk("R2", "p3 cle gap 6", longint'(cle_gap), 6);
    chk("R4", "p3 hold from ce hold", longint'(hold), 8);
  endtask

  task automatic t_saturate();
    set_cfg(1, 100000, 100000, 16000, 900000, 20000, 300000, 1000, 1000, 1000,
            1000, 1000, 400000, 999000, 1000);
    run_calc("R2");
    check_all("saturate");
    chk("R2", "ale gap 15 exact", longint'(ale_gap), 15);
    chk("R2", "cle gap saturated", longint'(cle_gap), 15);
    chk("R3", "hiz saturated", longint'(hiz), 255);
    chk("R5", "wait saturated", longint'(wt), 255);
  endtask

  task automatic t_floor_zero();
    set_cfg(7, 30000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    run_calc("R4");
    check_all("all zero");
    chk("R4", "hold floor", longint'(hold), 1);
    chk("R5", "wait floor", longint'(wt), 1);
    chk("R6", "setup floor", longint'(setup), 1);
    chk("R2", "cle no underflow", longint'(cle_gap), 0);
    chk("R3", "hiz zero", longint'(hiz), 0);
  endtask

  task automatic t_clamp();
    set_cfg(5, 35000, 5000, 5000, 5000, 12000, 1000, 1000, 1000, 1000,
            1000, 1000, 9000, 30000, 10000);
    run_calc("R6");
    check_all("negative diff");
    chk("R3", "hiz clamped", longint'(hiz), 0);
    chk("R6", "setup from access diff", longint'(setup), 3);
  endtask

  task automatic t_truncate();
    set_cfg(1, 30000, 1999, 2999, 13999, 12000, 1999, 0, 0, 0, 0, 0, 2999, 0, 0);
    run_calc("R10");
    check_all("truncate");
    chk("R10", "cle 1999ps as 1ns", longint'(cle_gap), 0);
    chk("R10", "ale 2999ps as 2ns", longint'(ale_gap), 1);
    chk("R10", "hiz 1999ps as 1ns", longint'(hiz), 1);
    chk("R10", "hold 1999ps as 1ns", longint'(hold), 1);
  endtask

  task automatic t_unsupported();
    set_cfg(10, 29999, 90000, 90000, 90000, 1000, 90000, 0, 0, 0, 0, 0, 90000, 0, 0);
    pulse_start();
    chk("R1", "done one cycle after start", longint'(done), 1);
    chk("R1", "unsupported high", longint'(unsup), 1);
    chk("R1", "ctrl word zero", longint'(ctrl_word), 0);
    chk("R1", "timing word zero", longint'(timing_word), 0);
    chk("R1", "hold field zero", longint'(hold), 0);
    @(negedge clk);
    chk("R8", "unsupported done single", longint'(done), 0);
    rc = 30000;
    run_calc("R1");
    check_all("rc boundary 30000");
  endtask

  task automatic t_busy_start();
    int extra = 0;
    set_cfg(4, 40000, 17000, 9000, 21000, 6000, 8000, 3000, 3000, 3000,
            3000, 3000, 13000, 20000, 2000);
    pulse_start();
    repeat (5) @(negedge clk);
    clr = 60000; ar = 60000; dh = 200000;
    pulse_start();
    wait_done("R8");
    clr = 17000; ar = 9000; dh = 8000;
    check_all("busy start ignored");
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk("R8", "no queued done", extra, 0);
  endtask

  task automatic t_stable();
    logic [31:0] cw, tw;
    cw = ctrl_word; tw = timing_word;
    set_cfg(2, 10000, 80000, 80000, 80000, 1000, 80000, 0, 0, 0, 0, 0, 80000, 0, 0);
    repeat (100) @(negedge clk);
    chk("R9", "ctrl word held", longint'(ctrl_word), longint'(cw));
    chk("R9", "timing word held", longint'(timing_word), longint'(tw));
    chk("R9", "unsupported held", longint'(unsup), 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    set_cfg(10, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_saturate();
    t_floor_zero();
    t_clamp();
    t_truncate();
    t_unsupported();
    t_busy_start();
    t_stable();
    finish_run();
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, 0);
    finish_run();
  end
endmodule